// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block derives the serial clock of a SPI host from its functional clock. An 8-bit divider code sets the length of each SCLK half period in functional clock cycles. A polarity bit sets the level at which SCLK rests, and a phase bit decides which SCLK edge captures data and which edge shifts it out. A transfer sequencer raises a run request to start SCLK and lowers it to stop. The block then brings SCLK back to its resting level, and it never cuts an active half period short.

Next to the pin, the block gives the shift logic two single-cycle strobes. The launch strobe means "drive the next bit" and the sample strobe means "capture the incoming bit". Each strobe is high for the one functional clock cycle that follows the SCLK edge it stands for, so the shift logic acts at the rising clock edge that ends that cycle. The all-ones divider code is a bypass: SCLK then runs at the functional clock rate, and one bit passes per functional cycle.

Top module: `spi_sclk_gen`

## Requirements
- R1: While reset is asserted, and right after it, SCLK, the launch strobe and the sample strobe are all 0.
- R2: While no transfer runs, SCLK equals the polarity input, registered with one cycle of lag (1 = rest high, 0 = rest low), and neither strobe pulses.
- R3: For a divider code d from 0 to 254, each SCLK half period lasts d+1 functional cycles, so the full period is 2*(d+1). The first edge away from the resting level comes d+1 cycles after the cycle in which the run request is taken.
- R4: With phase bit 0, the sample strobe pulses in the cycle after each leading (away-from-rest) edge. The launch strobe pulses after each trailing edge, and also once in the first cycle of a run.
- R5: With phase bit 1, the launch strobe pulses after each leading edge and the sample strobe pulses after each trailing edge. No launch strobe is issued at the start of a run.
- R6: If the run request is low while SCLK is at its resting level, the generator returns to idle at the next edge. If SCLK is at its active level, the generator first completes that half period with its trailing edge and then returns to idle.
- R7: Divider code 255 selects bypass. While running in bypass, SCLK is at the resting level while the functional clock is high and at the opposite level while it is low, and both strobes are high in every running cycle.
- R8: The divider code, polarity and phase are captured when a run starts. Changes to them during a run have no effect until the generator is idle again.
- R9: Outside bypass, the launch and sample strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Asynchronous reset, active low |
| divCode | input | 8 | Half-period divider code; 255 selects bypass |
| cpol | input | 1 | Resting level of SCLK |
| cpha | input | 1 | Phase: 0 samples on the leading edge, 1 launches on it |
| runReq | input | 1 | Run request from the transfer sequencer |
| sclk | output | 1 | Serial clock pin |
| launchStb | output | 1 | One-cycle strobe: shift out the next bit |
| sampleStb | output | 1 | One-cycle strobe: capture the incoming bit |

## Verification
The bench builds the block with its default 8-bit divider width and with bypass enabled, which brings the all-ones bypass code and the largest normal code of 254 within reach. A behavioural model runs in step with the design and is compared with it in every cycle, checking SCLK in both phases of the functional clock. Directed runs cover both polarities with both phases, divider codes 0, 2, 3, 4 and 254, stops taken in either SCLK half, and settings changed in the middle of a run.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  // Command word passed from the sequencing control to the pin/strobe datapath
  typedef struct packed {
    logic hold;        // force SCLK register to the resting level
    logic idleLevel;   // resting level in force this cycle
    logic lead;        // edge away from rest at the coming clock edge
    logic trail;       // edge back to rest at the coming clock edge
    logic start;       // a run begins at the coming clock edge
    logic cpha;        // phase in force this cycle
    logic bypassNext;  // the coming cycle is a running bypass cycle
  } sclk_cmd_t;
endpackage

// File: rtl/sclk_ctrl.sv
module sclk_ctrl
  import spi_sclk_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter bit BYPASS_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divCode,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             runReq,
  output sclk_cmd_t        cmd
);
  localparam logic [DIV_W-1:0] BYPASS_CODE = '1;

  logic             running;
  logic             activeHalf;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] divShadow;
  logic             cpolS;
  logic             cphaS;

  logic liveBypass;
  logic heldBypass;

  generate
    if (BYPASS_EN) begin : g_bypass
      assign liveBypass = (divCode == BYPASS_CODE);
      assign heldBypass = (divShadow == BYPASS_CODE);
    end else begin : g_nobypass
      assign liveBypass = 1'b0;
      assign heldBypass = 1'b0;
    end
  endgenerate

  logic halfDone, startNow, stopNow, leadNow, trailNow;

  always_comb begin
    halfDone = (cnt == divShadow);
    startNow = !running && runReq;
    stopNow  = running && !runReq && (heldBypass || !activeHalf);
    leadNow  = running && !heldBypass && !activeHalf && runReq && halfDone;
    trailNow = running && !heldBypass && activeHalf && halfDone;

    cmd.hold       = !running || stopNow;
    cmd.idleLevel  = running ? cpolS : cpol;
    cmd.lead       = leadNow;
    cmd.trail      = trailNow;
    cmd.start      = startNow;
    cmd.cpha       = running ? cphaS : cpha;
    cmd.bypassNext = (startNow && liveBypass) || (running && heldBypass && runReq);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running    <= 1'b0;
      activeHalf <= 1'b0;
      cnt        <= '0;
      divShadow  <= '0;
      cpolS      <= 1'b0;
      cphaS      <= 1'b0;
    end else if (!running) begin
      divShadow  <= divCode;
      cpolS      <= cpol;
      cphaS      <= cpha;
      cnt        <= '0;
      activeHalf <= 1'b0;
      running    <= runReq;
    end else if (stopNow) begin
      running    <= 1'b0;
      cnt        <= '0;
      activeHalf <= 1'b0;
    end else if (!heldBypass) begin
      if (halfDone) begin
        cnt        <= '0;
        activeHalf <= ~activeHalf;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: the half-period counter never passes the captured divider code
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    (running && !heldBypass) |-> (cnt <= divShadow));

  // R8: settings captured at start stay frozen while running
  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    running |=> ($stable(divShadow) && $stable(cpolS) && $stable(cphaS)));

  // R6: a leading edge never starts once the request has been withdrawn
  assert_no_lead_after_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (running && !runReq && !activeHalf) |=> !activeHalf);
endmodule

// File: rtl/sclk_datapath.sv
module sclk_datapath
  import spi_sclk_pkg::*;
#(
  parameter bit BYPASS_EN = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  sclk_cmd_t cmd,
  output logic      sclk,
  output logic      launchStb,
  output logic      sampleStb
);
  logic sclkReg;
  logic launchQ;
  logic sampleQ;
  logic bypassQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkReg <= 1'b0;
      launchQ <= 1'b0;
      sampleQ <= 1'b0;
      bypassQ <= 1'b0;
    end else begin
      if (cmd.hold)       sclkReg <= cmd.idleLevel;
      else if (cmd.lead)  sclkReg <= ~cmd.idleLevel;
      else if (cmd.trail) sclkReg <= cmd.idleLevel;

      bypassQ <= cmd.bypassNext;
      launchQ <= cmd.bypassNext
               | (cmd.start & ~cmd.cpha & ~cmd.bypassNext)
               | (cmd.lead  &  cmd.cpha)
               | (cmd.trail & ~cmd.cpha);
      sampleQ <= cmd.bypassNext
               | (cmd.lead  & ~cmd.cpha)
               | (cmd.trail &  cmd.cpha);
    end
  end

  generate
    if (BYPASS_EN) begin : g_pin_bypass
      // Bypass: resting level in the high clock phase, active level in the low phase
      assign sclk = bypassQ ? (sclkReg ^ ~clk) : sclkReg;
    end else begin : g_pin_plain
      assign sclk = sclkReg;
    end
  endgenerate

  assign launchStb = launchQ;
  assign sampleStb = sampleQ;

  // R2: no strobe follows a cycle spent idle or stopping
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.hold && !cmd.start) |=> (!launchQ && !sampleQ));

  // R9: outside bypass the two strobes are exclusive
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !bypassQ |-> !(launchQ && sampleQ));

  // R4: every divided SCLK edge is followed by exactly one strobe
  assert_edge_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.lead || cmd.trail) |=> ($countones({launchQ, sampleQ}) == 1));
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter bit BYPASS_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divCode,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             runReq,
  output logic             sclk,
  output logic             launchStb,
  output logic             sampleStb
);
  sclk_cmd_t cmd;

  sclk_ctrl #(.DIV_W(DIV_W), .BYPASS_EN(BYPASS_EN)) u_ctrl (
    .clk(clk), .rstN(rstN), .divCode(divCode), .cpol(cpol),
    .cpha(cpha), .runReq(runReq), .cmd(cmd)
  );

  sclk_datapath #(.BYPASS_EN(BYPASS_EN)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sclk(sclk),
    .launchStb(launchStb), .sampleStb(sampleStb)
  );

  // R1: outputs quiet right after reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!launchStb && !sampleStb));
endmodule

// File: tb/spi_sclk_gen_test.sv
module spi_sclk_gen_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] divCode = 8'd0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       runReq = 1'b0;
  logic       sclk, launchStb, sampleStb;

  int    checks = 0;
  int    fails = 0;
  string phaseReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sclk_gen uut (
    .clk(clk), .rstN(rstN), .divCode(divCode), .cpol(cpol), .cpha(cpha),
    .runReq(runReq), .sclk(sclk), .launchStb(launchStb), .sampleStb(sampleStb)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit mRun, mAct, mSclk, mL, mS, mCpol, mCpha;
  int mCnt, mDiv;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRun = 0; mAct = 0; mSclk = 0; mL = 0; mS = 0;
      mCpol = 0; mCpha = 0; mCnt = 0; mDiv = 0;
    end else begin
      mL = 0; mS = 0;
      if (!mRun) begin
        mDiv = divCode; mCpol = cpol; mCpha = cpha;
        mSclk = cpol; mCnt = 0; mAct = 0;
        if (runReq) begin
          mRun = 1;
          if (mDiv == 255) begin mL = 1; mS = 1; end
          else if (!mCpha) mL = 1;
        end
      end else if (mDiv == 255) begin
        if (!runReq) begin mRun = 0; mSclk = mCpol; end
        else begin mL = 1; mS = 1; end
      end else if (!mAct && !runReq) begin
        mRun = 0; mSclk = mCpol; mCnt = 0;
      end else if (mCnt == mDiv) begin
        mCnt = 0;
        mAct = !mAct;
        mSclk = mCpol ^ mAct;
        if (mAct) begin if (mCpha) mL = 1; else mS = 1; end
        else      begin if (mCpha) mS = 1; else mL = 1; end
      end else begin
        mCnt++;
      end
    end
  end

  // Low clock phase: full comparison
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      automatic bit byp = mRun && (mDiv == 255);
      chk(phaseReq, sclk, mSclk ^ byp);
      chk(phaseReq, launchStb, mL);
      chk(phaseReq, sampleStb, mS);
      if (!byp) chk("R9", launchStb & sampleStb, 0);
    end
  end

  // High clock phase: SCLK at the registered level (resting level in bypass)
  always @(posedge clk) begin
    #2;
    if (rstN) chk(phaseReq, sclk, mSclk);
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
    #3;
  endtask

  // Counts cycles between two consecutive leading edges
  task automatic measurePeriod(input logic lvl, input int expCyc, input string tag);
    int n;
    do @(negedge clk); while (sclk !== lvl);
    do @(negedge clk); while (sclk === lvl);
    n = 0;
    do begin @(negedge clk); n++; end while (sclk !== lvl);
    do begin @(negedge clk); n++; end while (sclk === lvl);
    chk(tag, n, expCyc);
    #3;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    phaseReq = "R1";
    waitCyc(3);
    chk("R1", sclk, 0);
    chk("R1", launchStb, 0);
    chk("R1", sampleStb, 0);
    rstN = 1'b1;
    waitCyc(2);
    chk("R1", sclk, 0);

    // R2: idle level follows polarity, no strobes
    phaseReq = "R2";
    cpol = 1'b1; waitCyc(3);
    chk("R2", sclk, 1);
    divCode = 8'd5; cpol = 1'b0; waitCyc(3);
    chk("R2", sclk, 0);

    // R3 / R4: divided run, phase 0
    phaseReq = "R4";
    divCode = 8'd3; cpha = 1'b0; cpol = 1'b0; runReq = 1'b1;
    measurePeriod(1'b0, 8, "R3");
    waitCyc(20);
    runReq = 1'b0; waitCyc(20);

    // R5: phase 1, rest high, minimum divider
    phaseReq = "R5";
    divCode = 8'd0; cpha = 1'b1; cpol = 1'b1; waitCyc(2);
    runReq = 1'b1;
    measurePeriod(1'b1, 2, "R3");
    waitCyc(15);
    runReq = 1'b0; waitCyc(10);

    // R8: settings changed mid-run take effect only from the next run
    phaseReq = "R8";
    divCode = 8'd2; cpol = 1'b1; cpha = 1'b1; waitCyc(2);
    runReq = 1'b1; waitCyc(5);
    divCode = 8'd7; cpol = 1'b0; cpha = 1'b0;
    measurePeriod(1'b1, 6, "R8");
    runReq = 1'b0; waitCyc(15);
    chk("R8", sclk, 0);
    runReq = 1'b1;
    measurePeriod(1'b0, 16, "R8");
    runReq = 1'b0; waitCyc(30);

    // R6: stop requested while SCLK is at its active level
    phaseReq = "R6";
    divCode = 8'd4; cpol = 1'b0; cpha = 1'b0; waitCyc(2);
    runReq = 1'b1;
    do @(negedge clk); while (sclk !== 1'b1);
    #3;
    runReq = 1'b0;
    waitCyc(2);
    chk("R6", sclk, 1);
    waitCyc(20);
    chk("R6", sclk, 0);
    chk("R6", launchStb, 0);
    chk("R6", sampleStb, 0);
    // stop requested while at rest, right after a start
    runReq = 1'b1; waitCyc(2);
    runReq = 1'b0; waitCyc(8);
    chk("R6", sclk, 0);

    // R7: bypass with both polarities
    phaseReq = "R7";
    divCode = 8'd255; cpol = 1'b0; waitCyc(2);
    runReq = 1'b1; waitCyc(10);
    runReq = 1'b0; waitCyc(4);
    cpol = 1'b1; waitCyc(2);
    runReq = 1'b1; waitCyc(10);
    runReq = 1'b0; waitCyc(4);
    chk("R7", sclk, 1);

    // R3: largest normal divider
    phaseReq = "R3";
    divCode = 8'd254; cpol = 1'b0; cpha = 1'b1; waitCyc(2);
    runReq = 1'b1;
    measurePeriod(1'b0, 510, "R3");
    runReq = 1'b0; waitCyc(600);
    chk("R3", sclk, 0);

    summary();
    $finish;
  end
endmodule